// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit

This block takes one floating-point operand per cycle, in either single (32-bit) or double (64-bit) precision, and rounds it to an integral value. The result stays in the same floating-point format as the operand. The rounding direction is not fixed by the request. It comes at run time from a 2-bit mode field held in a small control register. Along with each result the block raises an inexact flag whenever rounding changed the operand.

The mode field is written through a dedicated field-write port. A write ORs the new bits into the stored field, so a bit stays set until reset clears it. The stored field can be read back at any time. An operation is issued by pulsing the request-valid input, with the precision select and the operand held alongside it. The result and its flag appear on the output registers on the following clock edge.

Top module: `fround_unit`

## Requirements
- R1: The mode field resets to 0. A write ORs the 2-bit write value into the stored field, and the read port always shows the stored field. A zero write therefore changes nothing, and writing 1 and then 2 reads back 3.
- R2: A request sampled at a clock edge produces `res_valid` high with its result after that same edge, for exactly one cycle. `res_valid` is low in every cycle whose previous edge saw no request. A mode write takes effect for requests sampled at later edges only.
- R3: Mode 0 (nearest) returns whichever of the floor and the ceiling lies closer to the operand.
- R4: In mode 0, an operand exactly halfway between two integers rounds to the even one (0.5 gives 0, 1.5 gives 2, 2.5 gives 2, 3.5 gives 4).
- R5: Mode 1 (toward zero) returns the floor of positive operands and the ceiling of negative ones.
- R6: Mode 2 returns the ceiling and mode 3 returns the floor.
- R7: The result keeps the operand's sign bit. For example, -0.3 rounded by ceiling gives -0.0, and 0.3 rounded by ceiling gives 1.0. A carry out of the fraction correctly bumps the exponent.
- R8: `res_inexact` is high with a result exactly when the result's bits differ from the operand's bits, and it is low whenever `res_valid` is low.
- R9: NaN, infinity, zero, and operands with an unbiased exponent at or above the mantissa width pass through unchanged, with `res_inexact` low.
- R10: With `op_dbl` low, only `op_data[31:0]` is used as a single-precision value and `res_data[63:32]` is zero. With `op_dbl` high, all 64 bits form a double-precision value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_en | input | 1 | Field write strobe for the rounding mode |
| mode_wr_data | input | 2 | Bits ORed into the stored mode field |
| mode_rd | output | 2 | Stored rounding mode field |
| op_valid | input | 1 | Rounding request |
| op_dbl | input | 1 | 1 selects double precision, 0 selects single |
| op_data | input | 64 | Operand (single uses bits 31:0) |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_data | output | 64 | Rounded value in the operand's format |
| res_inexact | output | 1 | Result differs from the operand |

## Verification
Each rounding result is due exactly one clock edge after its request. The bench raises the request at a falling edge, lets one rising edge pass, and samples the result, flag and valid at the next falling edge. It then checks that valid has dropped again one cycle later. A mode write becomes visible on the read port after the edge that samples it. The bench reads it back at the following falling edge and also issues a request in the same cycle as a write, which confirms that the old mode still governs that request.

// File: rtl/fround_pkg.sv
package fround_pkg;

    localparam int MODE_W  = 2;
    localparam int DATA_W  = 64;
    localparam int SP_EXP  = 8;
    localparam int SP_MAN  = 23;
    localparam int DP_EXP  = 11;
    localparam int DP_MAN  = 52;
    localparam int SP_W    = 1 + SP_EXP + SP_MAN;
    localparam int DP_W    = 1 + DP_EXP + DP_MAN;

    typedef enum logic [MODE_W-1:0] {
        RM_NEAREST = 2'd0,
        RM_TOZERO  = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rmode_e;

    typedef struct packed {
        logic              valid;
        logic              inexact;
        logic [DATA_W-1:0] data;
    } rnd_result_t;

    // Decide whether the magnitude moves away from zero, given the discarded
    // fraction split into its top bit (half) and the bits below it (rest).
    function automatic logic round_away(rmode_e m, logic sgn, logic half,
                                        logic rest, logic odd);
        logic lost;
        lost = half | rest;
        case (m)
            RM_NEAREST: round_away = half & (rest | odd);
            RM_TOZERO:  round_away = 1'b0;
            RM_UP:      round_away = ~sgn & lost;
            RM_DOWN:    round_away = sgn & lost;
            default:    round_away = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fround_mode_reg.sv
module fround_mode_reg
    import fround_pkg::*;
#(
    parameter int FIELD_W = MODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_bits,
    output logic [FIELD_W-1:0] field_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            field_q <= '0;
        end else if (wr_en) begin
            field_q <= field_q | wr_bits;
        end
    end

endmodule

// File: rtl/fround_core.sv
module fround_core
    import fround_pkg::*;
#(
    parameter int EXP_W = SP_EXP,
    parameter int MAN_W = SP_MAN
) (
    input  logic [EXP_W+MAN_W:0] x,
    input  rmode_e               mode,
    output logic [EXP_W+MAN_W:0] y,
    output logic                 inexact
);

    localparam int MAG_W = EXP_W + MAN_W;
    localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
    localparam int SH_W  = $clog2(MAN_W + 1);
    localparam logic [EXP_W-1:0] EXP_INT  = EXP_W'(BIAS + MAN_W);
    localparam logic [EXP_W-1:0] EXP_ONE  = EXP_W'(BIAS);
    localparam logic [EXP_W-1:0] EXP_HALF = EXP_W'(BIAS - 1);

    logic             sgn;
    logic [EXP_W-1:0] expo;
    logic [MAN_W-1:0] man;
    logic [MAG_W-1:0] mag;
    logic             whole;
    logic             tiny;
    logic [SH_W-1:0]  sh;
    logic [MAG_W-1:0] unit;
    logic [MAG_W-1:0] frac_mask;
    logic [MAG_W-1:0] half_mask;
    logic [MAG_W-1:0] trunc_mag;
    logic             half;
    logic             rest;
    logic             odd;
    logic             up;
    logic [MAG_W-1:0] out_mag;

    assign sgn   = x[MAG_W];
    assign expo  = x[MAG_W-1:MAN_W];
    assign man   = x[MAN_W-1:0];
    assign mag   = x[MAG_W-1:0];

    // Already integral (includes NaN and infinity) or magnitude below one.
    assign whole = (expo >= EXP_INT);
    assign tiny  = (expo < EXP_ONE);

    // Number of fraction bits still inside the mantissa field.
    assign sh        = SH_W'(EXP_INT - expo);
    assign unit      = MAG_W'(1) << sh;
    assign frac_mask = unit - MAG_W'(1);
    assign half_mask = unit >> 1;

    always_comb begin
        if (tiny) begin
            trunc_mag = '0;
            half      = (expo == EXP_HALF);
            rest      = (expo == EXP_HALF) ? (man != '0) : (mag != '0);
            odd       = 1'b0;
        end else begin
            trunc_mag = mag & ~frac_mask;
            half      = |(mag & half_mask);
            rest      = |(mag & (half_mask - MAG_W'(1)));
            odd       = |(mag & unit);
        end
    end

    assign up = round_away(mode, sgn, half, rest, odd);

    always_comb begin
        if (!up) begin
            out_mag = trunc_mag;
        end else if (tiny) begin
            out_mag = {EXP_ONE, {MAN_W{1'b0}}};
        end else begin
            out_mag = trunc_mag + unit;
        end
    end

    always_comb begin
        if (whole) begin
            y       = x;
            inexact = 1'b0;
        end else begin
            y       = {sgn, out_mag};
            inexact = half | rest;
        end
    end

endmodule

// File: rtl/fround_unit.sv
module fround_unit
    import fround_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr_en,
    input  logic [MODE_W-1:0] mode_wr_data,
    output logic [MODE_W-1:0] mode_rd,
    input  logic              op_valid,
    input  logic              op_dbl,
    input  logic [DATA_W-1:0] op_data,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_data,
    output logic              res_inexact
);

    logic [MODE_W-1:0] mode_q;
    rmode_e            mode_cur;
    logic [SP_W-1:0]   sp_y;
    logic              sp_inx;
    logic [DP_W-1:0]   dp_y;
    logic              dp_inx;
    logic [DATA_W-1:0] sel_data;
    logic              sel_inx;
    rnd_result_t       res_q;

    fround_mode_reg #(.FIELD_W(MODE_W)) mode_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (mode_wr_en),
        .wr_bits (mode_wr_data),
        .field_q (mode_q)
    );

    assign mode_cur = rmode_e'(mode_q);

    fround_core #(.EXP_W(SP_EXP), .MAN_W(SP_MAN)) sp_i (
        .x       (op_data[SP_W-1:0]),
        .mode    (mode_cur),
        .y       (sp_y),
        .inexact (sp_inx)
    );

    fround_core #(.EXP_W(DP_EXP), .MAN_W(DP_MAN)) dp_i (
        .x       (op_data[DP_W-1:0]),
        .mode    (mode_cur),
        .y       (dp_y),
        .inexact (dp_inx)
    );

    always_comb begin
        if (op_dbl) begin
            sel_data = DATA_W'(dp_y);
            sel_inx  = dp_inx;
        end else begin
            sel_data = DATA_W'(sp_y);
            sel_inx  = sp_inx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid   <= op_valid;
            res_q.inexact <= op_valid & sel_inx;
            if (op_valid) begin
                res_q.data <= sel_data;
            end
        end
    end

    assign mode_rd     = mode_q;
    assign res_valid   = res_q.valid;
    assign res_data    = res_q.data;
    assign res_inexact = res_q.inexact;

endmodule

// File: rtl/fround_unit_chk.sv
module fround_unit_chk
    import fround_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mode_wr_en,
    input logic [MODE_W-1:0] mode_rd,
    input logic              op_valid,
    input logic              op_dbl,
    input logic [DATA_W-1:0] op_data,
    input logic              res_valid,
    input logic [DATA_W-1:0] res_data,
    input logic              res_inexact
);

    // R1
    mode_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wr_en |=> ((mode_rd & $past(mode_rd)) == $past(mode_rd)));

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_wr_en |=> $stable(mode_rd));

    // R2
    res_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    // R2
    res_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);

    // R8
    inexact_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        res_inexact |-> res_valid);

    // R8
    inexact_iff_change_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (res_inexact != (res_data == ($past(op_dbl) ? $past(op_data)
                                       : {32'h0, $past(op_data[31:0])}))));

    // R9
    dp_special_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_dbl && (&op_data[62:52]))
        |=> (res_data == $past(op_data) && !res_inexact));

    // R10
    sp_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_dbl) |=> (res_data[63:32] == 32'h0));

endmodule

bind fround_unit fround_unit_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .mode_wr_en  (mode_wr_en),
    .mode_rd     (mode_rd),
    .op_valid    (op_valid),
    .op_dbl      (op_dbl),
    .op_data     (op_data),
    .res_valid   (res_valid),
    .res_data    (res_data),
    .res_inexact (res_inexact)
);

// File: tb/fround_unit_tb_top.sv
module fround_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 30;

    // {mode(2), dbl(1), operand(64), expected(64), inexact(1)}
    localparam logic [131:0] VEC [NVEC] = '{
        {2'd0, 1'b0, 64'h0000000040200000, 64'h0000000040000000, 1'b1}, // R4 2.5->2
        {2'd0, 1'b0, 64'h0000000040600000, 64'h0000000040800000, 1'b1}, // R4 3.5->4
        {2'd0, 1'b0, 64'h000000003F000000, 64'h0000000000000000, 1'b1}, // R4 0.5->0
        {2'd0, 1'b0, 64'h000000003FC00000, 64'h0000000040000000, 1'b1}, // R4 1.5->2
        {2'd0, 1'b0, 64'h000000003F400000, 64'h000000003F800000, 1'b1}, // R3 0.75->1
        {2'd0, 1'b0, 64'h00000000BFC00000, 64'h00000000C0000000, 1'b1}, // R4 -1.5->-2
        {2'd0, 1'b0, 64'h000000003FA00000, 64'h000000003F800000, 1'b1}, // R3 1.25->1
        {2'd0, 1'b0, 64'h000000004AFFFFFF, 64'h000000004B000000, 1'b1}, // R7 carry
        {2'd1, 1'b0, 64'h00000000C0200000, 64'h00000000C0000000, 1'b1}, // R5 -2.5->-2
        {2'd1, 1'b0, 64'h000000003F333333, 64'h0000000000000000, 1'b1}, // R5 0.7->0
        {2'd2, 1'b0, 64'h000000003FA00000, 64'h0000000040000000, 1'b1}, // R6 1.25->2
        {2'd2, 1'b0, 64'h00000000BFC00000, 64'h00000000BF800000, 1'b1}, // R6 -1.5->-1
        {2'd2, 1'b0, 64'h000000003E99999A, 64'h000000003F800000, 1'b1}, // R7 0.3->1
        {2'd2, 1'b0, 64'h00000000BE99999A, 64'h0000000080000000, 1'b1}, // R7 -0.3->-0
        {2'd3, 1'b0, 64'h000000003FC00000, 64'h000000003F800000, 1'b1}, // R6 1.5->1
        {2'd3, 1'b0, 64'h00000000BE99999A, 64'h00000000BF800000, 1'b1}, // R6 -0.3->-1
        {2'd3, 1'b0, 64'h0000000040400000, 64'h0000000040400000, 1'b0}, // R8 3.0 exact
        {2'd0, 1'b1, 64'h4004000000000000, 64'h4000000000000000, 1'b1}, // R4 dp 2.5
        {2'd0, 1'b1, 64'hC004000000000000, 64'hC000000000000000, 1'b1}, // R4 dp -2.5
        {2'd2, 1'b1, 64'h4004000000000000, 64'h4008000000000000, 1'b1}, // R6 dp 2.5->3
        {2'd3, 1'b1, 64'hBFF8000000000000, 64'hC000000000000000, 1'b1}, // R6 dp -1.5
        {2'd1, 1'b1, 64'hBFF8000000000000, 64'hBFF0000000000000, 1'b1}, // R5 dp -1.5
        {2'd0, 1'b1, 64'h7FF8000000000000, 64'h7FF8000000000000, 1'b0}, // R9 NaN
        {2'd2, 1'b0, 64'h000000007F800000, 64'h000000007F800000, 1'b0}, // R9 inf
        {2'd3, 1'b1, 64'h43B0000000000000, 64'h43B0000000000000, 1'b0}, // R9 2^60
        {2'd0, 1'b0, 64'h000000004B800000, 64'h000000004B800000, 1'b0}, // R9 2^24
        {2'd0, 1'b1, 64'h0000000000000000, 64'h0000000000000000, 1'b0}, // R9 zero
        {2'd2, 1'b0, 64'h0000000000000001, 64'h000000003F800000, 1'b1}, // R7 subnormal
        {2'd0, 1'b1, 64'h3FF0000000000000, 64'h3FF0000000000000, 1'b0}, // R8 dp 1.0
        {2'd0, 1'b0, 64'hDEADBEEF40200000, 64'h0000000040000000, 1'b1}  // R10 upper ignored
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr_en = 1'b0;
    logic [1:0]  mode_wr_data = '0;
    logic [1:0]  mode_rd;
    logic        op_valid = 1'b0;
    logic        op_dbl = 1'b0;
    logic [63:0] op_data = '0;
    logic        res_valid;
    logic [63:0] res_data;
    logic        res_inexact;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fround_unit dut_i (
        .clk          (clk),
        .rst          (rst),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .mode_rd      (mode_rd),
        .op_valid     (op_valid),
        .op_dbl       (op_dbl),
        .op_data      (op_data),
        .res_valid    (res_valid),
        .res_data     (res_data),
        .res_inexact  (res_inexact)
    );

    task automatic check(input string req, input logic [63:0] got,
                         input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_mode(input logic [1:0] bits);
        mode_wr_en   = 1'b1;
        mode_wr_data = bits;
        @(negedge clk);
        mode_wr_en   = 1'b0;
        mode_wr_data = '0;
    endtask

    // Issue one request at a falling edge; results are sampled one edge later.
    task automatic issue(input logic dbl, input logic [63:0] d);
        op_valid = 1'b1;
        op_dbl   = dbl;
        op_data  = d;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        // Reset state (R1, R2)
        do_reset();
        check("R1 reset mode", 64'(mode_rd), 64'h0);
        check("R2 reset valid", 64'(res_valid), 64'h0);
        check("R8 reset inexact", 64'(res_inexact), 64'h0);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            write_mode(VEC[i][131:130]);
            check("R1 mode readback", 64'(mode_rd), 64'(VEC[i][131:130]));
            issue(VEC[i][129], VEC[i][128:65]);
            check($sformatf("R2 valid vec%0d", i), 64'(res_valid), 64'h1);
            check($sformatf("R3-6 data vec%0d", i), res_data, VEC[i][64:1]);
            check($sformatf("R8 inexact vec%0d", i), 64'(res_inexact), 64'(VEC[i][0]));
            @(negedge clk);
            check($sformatf("R2 valid drop vec%0d", i), 64'(res_valid), 64'h0);
        end

        // R1: OR accumulation and zero write
        do_reset();
        write_mode(2'd1);
        write_mode(2'd0);
        check("R1 zero write keeps", 64'(mode_rd), 64'h1);
        write_mode(2'd2);
        check("R1 or accumulate", 64'(mode_rd), 64'h3);
        issue(1'b0, 64'h3FC00000);
        check("R6 accumulated mode floors", res_data, 64'h3F800000);

        // R2: write in same cycle as request uses old mode
        do_reset();
        mode_wr_en   = 1'b1;
        mode_wr_data = 2'd2;
        issue(1'b0, 64'h3FA00000);
        mode_wr_en   = 1'b0;
        mode_wr_data = '0;
        check("R2 same-cycle write old mode", res_data, 64'h3F800000);
        issue(1'b0, 64'h3FA00000);
        check("R2 next request new mode", res_data, 64'h40000000);

        // R2: back-to-back requests each produce a result
        op_valid = 1'b1;
        op_dbl   = 1'b1;
        op_data  = 64'h4004000000000000;
        @(negedge clk);
        check("R2 b2b first", res_data, 64'h4008000000000000);
        op_data  = 64'hBFF8000000000000;
        @(negedge clk);
        op_valid = 1'b0;
        check("R2 b2b second", res_data, 64'hBFF0000000000000);
        check("R2 b2b valid", 64'(res_valid), 64'h1);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule